// File: doc/BRIEF.md
# Chip-Select Mode Serial ADC Read Controller

This block sits on the host side of an 18-bit successive-approximation converter that has a single serial output. It runs the whole read cycle itself. It raises the convert line to start a sample. It holds that line high while the conversion runs, then drops it, which enables the converter's data output. It then clocks 18 result bits in, most significant bit first. The converter's select input is tied high by this block, so every conversion starts in chip-select mode. The convert line frames the read, and no separate select wire is used.

A parameter sets how long the convert line stays high. The result is a two's-complement 18-bit word. It is sign-extended to 32 bits and offered on a valid/ready output. A result stays on the port until the consumer accepts it. While a result waits, no new conversion starts, so back-pressure slows the sampling rate and never loses a word.

When `enable` is high, a rate counter sets the shortest time from one conversion start to the next. A parameter selects busy-polling mode. In that mode the convert line is only pulsed briefly, and the block waits for the data line to go low before it reads. If the data line stays high too long, the block gives up with a one-cycle error pulse.

Top module: `adc_cs_reader`

## Requirements
- R1: During and after reset, `adc_cnv` and `adc_sck` are low, `adc_sdi` is high and `res_valid` is low.
- R2: `adc_sdi` is driven high at every rising edge of `adc_cnv`, which selects chip-select mode.
- R3: Each conversion holds `adc_cnv` high for exactly CNV_HI_CYC clock cycles. The default of 51 cycles at 100 MHz covers the 500 ns worst-case conversion time.
- R4: `adc_sck` stays low while `adc_cnv` is high. In fixed-delay mode, the first `adc_sck` rising edge comes EN_CYC+1 cycles after `adc_cnv` falls.
- R5: In fixed-delay mode, each conversion produces exactly 18 `adc_sck` pulses. Each pulse is high for SCK_HALF cycles and low for SCK_HALF cycles. `adc_sdo` is sampled on the clock edge that drives each `adc_sck` falling edge. The first sample is the MSB (bit 17) and the last is bit 0.
- R6: `res_data` carries the 18-bit word in bits 17:0. Bits 31:18 are all copies of bit 17.
- R7: Two consecutive rising edges of `adc_cnv` are at least PERIOD_CYC cycles apart.
- R8: Once `res_valid` is high, it stays high and `res_data` stays unchanged until a cycle with `res_ready` high. The word transfers in that cycle, and `res_valid` is low in the next cycle.
- R9: No rising edge of `adc_cnv` occurs while `res_valid` is high.
- R10: While `enable` is low and no conversion is in progress, `adc_cnv` stays low.
- R11: In busy-polling mode (BUSY_MODE=1), after the enable wait the block waits until `adc_sdo` is low. It then issues 19 `adc_sck` pulses and discards the first sample (the busy bit). The result is the following 18 bits, MSB first.
- R12: In busy-polling mode, if `adc_sdo` stays high for BUSY_TMO_CYC cycles, then `busy_timeout` is high for one cycle. No result is produced for that conversion, and the next conversion still follows the rate rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows new conversions to start |
| adc_cnv | output | 1 | Convert start line; it also frames the read |
| adc_sck | output | 1 | Serial clock to the converter |
| adc_sdo | input | 1 | Serial data (and busy bit) from the converter |
| adc_sdi | output | 1 | Mode select to the converter, held high |
| res_data | output | 32 | Sign-extended conversion result |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| busy_timeout | output | 1 | One-cycle pulse when busy polling times out |

## Verification
Some faults show up within one conversion frame at the converter pins:
- A sequencer counter that is off by one shows as a convert pulse of the wrong length or an early clock edge.
- A wrong bit counter shows as the wrong number of serial clock falling edges.

A broken shift path or sign extension shows on the very next result word, and a table of extreme codes exposes it. A flaw in the handshake state or rate state shows within one period. It appears as a lost or changed word while the consumer stalls, or as convert edges closer together than the set spacing. In busy-polling mode, an error in the discard or timeout state corrupts the next word or loses the error pulse. Either one shows within a single timeout window.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

  // Sequencer states of the read controller
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for rate slot, enable and a free output
    ST_CNV,    // convert line high
    ST_EN,     // convert line low, output enable settling
    ST_BUSY,   // polling data line for end of conversion
    ST_SHIFT   // serial clocking in progress
  } rd_state_e;

endpackage

// File: rtl/adc_rd_rate.sv
`timescale 1ns/1ps
module adc_rd_rate #(
  parameter int PERIOD_CYC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic due_o
);

  localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt;

  // Counts cycles since the last start and saturates; starts out "due"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= LAST;
    end else if (restart_i) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign due_o = (cnt == LAST);

endmodule

// File: rtl/adc_rd_serial.sv
`timescale 1ns/1ps
module adc_rd_serial #(
  parameter int DATA_W   = 18,
  parameter int NBITS    = 18,
  parameter int SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sdo_i,
  output logic              sck_o,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o
);

  localparam int PH_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int BC_W = $clog2(NBITS + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SCK_HALF - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(NBITS - 1);

  logic              active;
  logic              sck_r;
  logic [PH_W-1:0]   ph;
  logic [BC_W-1:0]   bc;
  logic [DATA_W-1:0] shreg;
  logic              done_r;

  // Each pulse: SCK_HALF cycles high, then SCK_HALF cycles low.
  // The data bit is taken on the edge that drops SCK, i.e. one full
  // SCK period after the falling edge that launched it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sck_r  <= 1'b0;
      ph     <= '0;
      bc     <= '0;
      shreg  <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start_i && !active) begin
        active <= 1'b1;
        sck_r  <= 1'b1;
        ph     <= '0;
        bc     <= '0;
      end else if (active) begin
        if (ph == PH_LAST) begin
          ph <= '0;
          if (sck_r) begin
            sck_r <= 1'b0;
            shreg <= {shreg[DATA_W-2:0], sdo_i};
            if (bc == BC_LAST) begin
              active <= 1'b0;
              done_r <= 1'b1;
            end else begin
              bc <= bc + 1'b1;
            end
          end else begin
            sck_r <= 1'b1;
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  assign sck_o  = sck_r;
  assign done_o = done_r;
  assign word_o = shreg;

endmodule

// File: rtl/adc_cs_reader.sv
`timescale 1ns/1ps
module adc_cs_reader
  import adc_rd_pkg::*;
#(
  parameter int DATA_W       = 18,
  parameter int OUT_W        = 32,
  parameter int PERIOD_CYC   = 128,
  parameter int CNV_HI_CYC   = 51,
  parameter int EN_CYC       = 2,
  parameter int SCK_HALF     = 2,
  parameter int BUSY_MODE    = 0,
  parameter int BUSY_TMO_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  output logic             adc_cnv,
  output logic             adc_sck,
  input  logic             adc_sdo,
  output logic             adc_sdi,
  output logic [OUT_W-1:0] res_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             busy_timeout
);

  localparam int NBITS   = DATA_W + ((BUSY_MODE != 0) ? 1 : 0);
  localparam int M1      = (CNV_HI_CYC > EN_CYC) ? CNV_HI_CYC : EN_CYC;
  localparam int CNT_TOP = (M1 > BUSY_TMO_CYC) ? M1 : BUSY_TMO_CYC;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);
  localparam int EXT_W   = OUT_W - DATA_W;
  localparam int GAP_W   = $clog2(PERIOD_CYC + 1);

  rd_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic              cnv_r;
  logic              ser_start;
  logic              ser_done;
  logic              err_r;
  logic              due;
  logic              start_conv;
  logic [DATA_W-1:0] ser_word;
  logic [OUT_W-1:0]  data_r;
  logic              valid_r;

  // A conversion starts only when the rate slot is open, software allows
  // it and the previous word has been taken (back-pressure).
  assign start_conv = (state == ST_IDLE) && enable && due && !valid_r;

  adc_rd_rate #(
    .PERIOD_CYC(PERIOD_CYC)
  ) i_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(start_conv),
    .due_o    (due)
  );

  adc_rd_serial #(
    .DATA_W  (DATA_W),
    .NBITS   (NBITS),
    .SCK_HALF(SCK_HALF)
  ) i_serial (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(ser_start),
    .sdo_i  (adc_sdo),
    .sck_o  (adc_sck),
    .done_o (ser_done),
    .word_o (ser_word)
  );

  // Conversion sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      cnv_r     <= 1'b0;
      ser_start <= 1'b0;
      err_r     <= 1'b0;
    end else begin
      ser_start <= 1'b0;
      err_r     <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_conv) begin
            state <= ST_CNV;
            cnt   <= '0;
            cnv_r <= 1'b1;
          end
        end
        ST_CNV: begin
          if (cnt == CNT_W'(CNV_HI_CYC - 1)) begin
            cnv_r <= 1'b0;
            cnt   <= '0;
            state <= ST_EN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_EN: begin
          if (cnt == CNT_W'(EN_CYC - 1)) begin
            cnt <= '0;
            if (BUSY_MODE != 0) begin
              state <= ST_BUSY;
            end else begin
              state     <= ST_SHIFT;
              ser_start <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_BUSY: begin
          if (!adc_sdo) begin
            state     <= ST_SHIFT;
            ser_start <= 1'b1;
          end else if (cnt == CNT_W'(BUSY_TMO_CYC - 1)) begin
            err_r <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (ser_done) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Output stage: sign-extended word held until accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_r  <= '0;
      valid_r <= 1'b0;
    end else if (ser_done) begin
      data_r  <= {{EXT_W{ser_word[DATA_W-1]}}, ser_word};
      valid_r <= 1'b1;
    end else if (res_ready) begin
      valid_r <= 1'b0;
    end
  end

  assign adc_cnv      = cnv_r;
  assign adc_sdi      = 1'b1;
  assign res_data     = data_r;
  assign res_valid    = valid_r;
  assign busy_timeout = err_r;

  // ---------------- checks ----------------
  logic             cnv_q;
  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_q   <= 1'b0;
      gap_cnt <= GAP_W'(PERIOD_CYC);
    end else begin
      cnv_q <= cnv_r;
      if (cnv_r && !cnv_q) begin
        gap_cnt <= GAP_W'(1);
      end else if (gap_cnt != GAP_W'(PERIOD_CYC)) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_r && !res_ready) |=> (valid_r && $stable(data_r)));

  // R9
  no_cnv_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_r |=> !$rose(cnv_r));

  // R4
  sck_quiet_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_r |-> !adc_sck);

  // R7
  cnv_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_r && !cnv_q) |-> (gap_cnt >= GAP_W'(PERIOD_CYC)));

  // R5
  done_in_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_done |-> (state == ST_SHIFT));

  // R12
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_r |=> (!err_r && !valid_r));

endmodule

// File: tb/test_adc_cs_reader.sv
`timescale 1ns/1ps
module adc_model #(
  parameter bit BUSY     = 1'b0,
  parameter int CONV_DLY = 300
) (
  input  logic        cnv,
  input  logic        sck,
  input  logic        sdi,
  input  logic        stuck,
  input  logic [17:0] smp,
  input  int          cyc,
  output logic        sdo
);
  int rises = 0, falls = 0, sdi_bad = 0, sck_in_cnv = 0;
  int hi_cyc = 0, first_gap = 0, min_gap = 1000000;
  int rise_cyc = 0, fall_cyc = 0, ptr = 0;
  bit first_pending = 1'b0;
  logic [17:0] word = '0;

  initial sdo = 1'b0;

  always @(posedge cnv) begin
    #1;
    if (sdi !== 1'b1) sdi_bad++;
    if (rises > 0 && (cyc - rise_cyc) < min_gap) min_gap = cyc - rise_cyc;
    rise_cyc = cyc;
    rises++;
    falls = 0;
    word = smp;
    ptr = 0;
    sdo = 1'b0;
  end

  always @(negedge cnv) begin
    #1;
    fall_cyc = cyc;
    hi_cyc = cyc - rise_cyc;
    first_pending = 1'b1;
    #2;
    if (BUSY) begin
      ptr = 18;
      sdo = 1'b1;
      #(CONV_DLY);
      if (!stuck && !cnv && ptr == 18) sdo = 1'b0;
    end else begin
      ptr = 17;
      sdo = word[17];
    end
  end

  always @(posedge sck) begin
    #1;
    if (cnv) sck_in_cnv++;
    if (first_pending) begin
      first_gap = cyc - fall_cyc;
      first_pending = 1'b0;
    end
  end

  always @(negedge sck) begin
    falls++;
    #3;
    if (ptr == 18) begin
      ptr = 17;
      sdo = word[17];
    end else if (ptr > 0) begin
      ptr--;
      sdo = word[ptr];
    end else begin
      sdo = 1'b0;
    end
  end
endmodule

module test_adc_cs_reader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // fixed-delay instance
  logic        enable = 1'b0, rdy = 1'b0;
  logic        cnv, sck, sdo, sdi, rv, tmo;
  logic [31:0] rd;
  logic [17:0] smp = '0;

  // busy-polling instance
  logic        enable_b = 1'b0, rdy_b = 1'b0, stuck = 1'b0;
  logic        cnv_b, sck_b, sdo_b, sdi_b, rv_b, tmo_b;
  logic [31:0] rd_b;
  logic [17:0] smp_b = '0;

  adc_cs_reader i_adc_cs_reader (
    .clk(clk), .rst_n(rst_n), .enable(enable), .adc_cnv(cnv), .adc_sck(sck),
    .adc_sdo(sdo), .adc_sdi(sdi), .res_data(rd), .res_valid(rv),
    .res_ready(rdy), .busy_timeout(tmo));

  adc_model i_model (
    .cnv(cnv), .sck(sck), .sdi(sdi), .stuck(1'b0), .smp(smp), .cyc(cyc), .sdo(sdo));

  adc_cs_reader #(.CNV_HI_CYC(2), .BUSY_MODE(1)) i_adc_cs_reader_busy (
    .clk(clk), .rst_n(rst_n), .enable(enable_b), .adc_cnv(cnv_b), .adc_sck(sck_b),
    .adc_sdo(sdo_b), .adc_sdi(sdi_b), .res_data(rd_b), .res_valid(rv_b),
    .res_ready(rdy_b), .busy_timeout(tmo_b));

  adc_model #(.BUSY(1'b1), .CONV_DLY(300)) i_model_b (
    .cnv(cnv_b), .sck(sck_b), .sdi(sdi_b), .stuck(stuck), .smp(smp_b), .cyc(cyc), .sdo(sdo_b));

  // {18-bit converter code, expected 32-bit result}
  localparam logic [49:0] VEC [8] = '{
    {18'h1FFFF, 32'h0001FFFF},
    {18'h20000, 32'hFFFE0000},
    {18'h00000, 32'h00000000},
    {18'h3FFFF, 32'hFFFFFFFF},
    {18'h15555, 32'h00015555},
    {18'h2AAAA, 32'hFFFEAAAA},
    {18'h00001, 32'h00000001},
    {18'h3FFFE, 32'hFFFFFFFE}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_res(input bit busy_side, output bit got);
    got = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (busy_side ? rv_b : rv) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    finish_run();
  end

  initial begin
    bit got;
    logic [31:0] held;
    int r0;
    bit stable;
    bit seen_err, seen_valid;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cnv == 1'b0 && sck == 1'b0 && sdi == 1'b1 && rv == 1'b0, "R1", "pins in reset",
        {28'd0, cnv, sck, sdi, rv}, 32'h2);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    // R1 after reset, R10 enable low keeps converter idle
    chk(cnv == 1'b0 && sck == 1'b0 && rv == 1'b0, "R1", "pins after reset",
        {29'd0, cnv, sck, rv}, 32'h0);
    chk(i_model.rises == 0, "R10", "conversions with enable low", i_model.rises, 0);

    // main vector walk: R5 R6 R3
    smp = VEC[0][49:32];
    rdy = 1'b1;
    enable = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wait_res(1'b0, got);
      smp = (i < 7) ? VEC[i+1][49:32] : 18'h2468A;
      chk(got && rd == VEC[i][31:0], "R6", "sign-extended word", rd, VEC[i][31:0]);
      chk(i_model.falls == 18, "R5", "sck pulses per word", i_model.falls, 18);
      chk(i_model.hi_cyc == 51, "R3", "cnv high cycles", i_model.hi_cyc, 51);
    end
    chk(i_model.first_gap == 3, "R4", "cnv fall to first sck", i_model.first_gap, 3);
    chk(i_model.min_gap >= 128, "R7", "cnv rise spacing", i_model.min_gap, 128);
    chk(i_model.sdi_bad == 0, "R2", "sdi low at cnv rise", i_model.sdi_bad, 0);

    // back-pressure: R8 R9
    @(negedge clk);
    rdy = 1'b0;
    wait_res(1'b0, got);
    chk(got && rd == 32'hFFFE468A, "R6", "word under stall", rd, 32'hFFFE468A);
    held = rd;
    r0 = i_model.rises;
    stable = 1'b1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!rv || rd != held) stable = 1'b0;
    end
    chk(stable, "R8", "word held while not ready", rd, held);
    chk(i_model.rises == r0, "R9", "cnv rises while word pending", i_model.rises, r0);
    rdy = 1'b1;
    @(negedge clk);
    chk(rv == 1'b0, "R8", "valid drops after transfer", {31'd0, rv}, 32'd0);
    enable = 1'b0;

    // busy-polling instance: R11
    smp_b = 18'h12345;
    rdy_b = 1'b1;
    enable_b = 1'b1;
    wait_res(1'b1, got);
    smp_b = 18'h3C001;
    chk(got && rd_b == 32'h00012345, "R11", "busy-mode word", rd_b, 32'h00012345);
    chk(i_model_b.falls == 19, "R11", "busy-mode sck pulses", i_model_b.falls, 19);
    chk(i_model_b.hi_cyc == 2, "R3", "busy-mode cnv high", i_model_b.hi_cyc, 2);
    wait_res(1'b1, got);
    stuck = 1'b1;
    chk(got && rd_b == 32'hFFFFC001, "R11", "busy-mode negative word", rd_b, 32'hFFFFC001);

    // timeout: R12
    seen_err = 1'b0;
    seen_valid = 1'b0;
    for (int k = 0; k < 2000 && !seen_err; k++) begin
      @(negedge clk);
      if (tmo_b) seen_err = 1'b1;
      if (rv_b) seen_valid = 1'b1;
    end
    chk(seen_err, "R12", "timeout pulse", {31'd0, seen_err}, 32'd1);
    @(negedge clk);
    chk(tmo_b == 1'b0 && !seen_valid && rv_b == 1'b0, "R12", "single pulse, no word",
        {30'd0, tmo_b, seen_valid}, 32'd0);
    stuck = 1'b0;
    smp_b = 18'h0ABCD;
    wait_res(1'b1, got);
    chk(got && rd_b == 32'h0000ABCD, "R12", "recovery after timeout", rd_b, 32'h0000ABCD);
    chk(i_model_b.min_gap >= 128, "R7", "busy-mode cnv spacing", i_model_b.min_gap, 128);
    chk(i_model.sck_in_cnv == 0 && i_model_b.sck_in_cnv == 0, "R4", "sck while cnv high",
        i_model.sck_in_cnv + i_model_b.sck_in_cnv, 0);
    chk(i_model_b.sdi_bad == 0, "R2", "busy-mode sdi at cnv rise", i_model_b.sdi_bad, 0);

    finish_run();
  end
endmodule